// File: doc/BRIEF.md
# Four-Phase Stepper Coil Sequencer

This block drives the four coil lines of a stepper motor through a repeating cycle of four full-step patterns. It is a Moore machine: the coil output is decoded from the current step alone, and the two direction inputs only decide which step follows. Each step keeps its pattern for a dwell interval that is set by a parameter per step. The dwell is measured in ticks of an enable strobe, so one free-running prescaler elsewhere on the chip can pace the motor.

When a dwell ends, the synchronised direction inputs are read once, and a per-step table picks the next step. Clockwise alone walks the cycle forward and counter-clockwise alone walks it backward. Neither input, or both inputs, keeps the motor on its current step. A single-cycle strobe marks every real change of coil pattern.

Top module: `stepper_seq`

## Requirements
- R1: During and right after synchronous reset, the coil output is 4'b0101 and the step strobe is low.
- R2: The coil output is always one of 4'b0101, 4'b0110, 4'b1010 and 4'b1001. It depends only on the current step, and bit n drives coil line n.
- R3: With the clockwise input high and the counter-clockwise input low, the coil output advances 0101 → 0110 → 1010 → 1001 → 0101.
- R4: With the counter-clockwise input high and the clockwise input low, the coil output advances 0101 → 1001 → 1010 → 0110 → 0101.
- R5: The table index is {cw, ccw}. Index 2'b00 (neither input) and index 2'b11 (both inputs) keep the current step, so the coil output and the step strobe do not change.
- R6: Each step has its own dwell parameter D (default 4000). With the tick strobe high in every cycle, a step change shows at the output D clock edges after the step was entered.
- R7: While the tick strobe is low, the dwell count stays frozen, and so do the coil output and the step strobe.
- R8: The dwell count restarts from zero each time a step is entered, including when the table keeps the same step.
- R9: Each direction input passes through two flip-flops. The synchronised value is read only in the cycle in which the dwell expires, so pulses that arrive and leave between expiries have no effect.
- R10: The step strobe is high for exactly one cycle: the first cycle in which the coil output shows a new pattern. It is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Dwell tick strobe |
| dir_cw | input | 1 | Clockwise request (asynchronous level) |
| dir_ccw | input | 1 | Counter-clockwise request (asynchronous level) |
| coil | output | 4 | Coil drive pattern, bit n drives line n |
| step_pulse | output | 1 | One-cycle strobe when the coil pattern changes |

## Verification
The bench builds the block with dwells of 3, 5, 2 and 4 ticks for the four steps instead of 4000. Every step therefore has a distinct interval, and a wrong dwell lookup shows up as a wrong edge count. These short dwells let complete forward and reverse revolutions, self-loop reloads and frozen-tick intervals finish in a few dozen cycles. With the two-tick dwell, a direction change that lands on the expiry edge arrives just too late for the two-stage synchroniser, so the bench can measure the synchroniser latency exactly.

// File: rtl/stepper_pkg.sv
package stepper_pkg;

  typedef logic [1:0] step_idx_t;

  localparam step_idx_t STEP_HOME = 2'd0;

  // Coil pattern of each step index; bit n drives coil line n
  function automatic logic [3:0] coil_of(input step_idx_t s);
    case (s)
      2'd0:    coil_of = 4'b0101;
      2'd1:    coil_of = 4'b0110;
      2'd2:    coil_of = 4'b1010;
      default: coil_of = 4'b1001;
    endcase
  endfunction

  // Next-step table, indexed by {cw, ccw}
  function automatic step_idx_t next_of(input step_idx_t s, input logic [1:0] sel);
    case (sel)
      2'b10:   next_of = s + 2'd1;
      2'b01:   next_of = s - 2'd1;
      default: next_of = s;
    endcase
  endfunction

endpackage

// File: rtl/stepper_sync.sv
module stepper_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1, stage2;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;

  // R9: the output only follows what the first stage held one cycle earlier
  p_two_stage_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> q == $past(stage1));
endmodule

// File: rtl/stepper_dwell.sv
module stepper_dwell
  import stepper_pkg::*;
#(
  parameter int DWELL_0 = 4000,
  parameter int DWELL_1 = 4000,
  parameter int DWELL_2 = 4000,
  parameter int DWELL_3 = 4000
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      tick_en,
  input  step_idx_t idx,
  output logic      expire
);
  localparam int MAX01 = (DWELL_0 > DWELL_1) ? DWELL_0 : DWELL_1;
  localparam int MAX23 = (DWELL_2 > DWELL_3) ? DWELL_2 : DWELL_3;
  localparam int DMAX  = (MAX01 > MAX23) ? MAX01 : MAX23;
  localparam int CW    = $clog2(DMAX + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  // Last tick count of the current step's dwell
  function automatic logic [CW-1:0] last_tick(input step_idx_t s);
    case (s)
      2'd0:    last_tick = CW'(DWELL_0 - 1);
      2'd1:    last_tick = CW'(DWELL_1 - 1);
      2'd2:    last_tick = CW'(DWELL_2 - 1);
      default: last_tick = CW'(DWELL_3 - 1);
    endcase
  endfunction

  assign lim    = last_tick(idx);
  assign expire = tick_en && (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (expire)  cnt <= '0;
    else if (tick_en) cnt <= cnt + 1'b1;
  end

  // R6: count never passes the dwell limit of the current step
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
    cnt <= lim);
  // R7: a missing tick freezes the count
  p_freeze_r7: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(cnt));
  // R8: every expiry restarts the dwell
  p_reload_r8: assert property (@(posedge clk) disable iff (rst)
    expire |=> cnt == '0);
endmodule

// File: rtl/stepper_seq.sv
module stepper_seq
  import stepper_pkg::*;
#(
  parameter int DWELL_0 = 4000,
  parameter int DWELL_1 = 4000,
  parameter int DWELL_2 = 4000,
  parameter int DWELL_3 = 4000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_en,
  input  logic       dir_cw,
  input  logic       dir_ccw,
  output logic [3:0] coil,
  output logic       step_pulse
);
  step_idx_t  cur_step;
  step_idx_t  nxt_step;
  logic [1:0] dir_sel;
  logic       dwell_done;

  stepper_sync #(.W(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({dir_cw, dir_ccw}),
    .q   (dir_sel)
  );

  stepper_dwell #(
    .DWELL_0 (DWELL_0),
    .DWELL_1 (DWELL_1),
    .DWELL_2 (DWELL_2),
    .DWELL_3 (DWELL_3)
  ) u_dwell (
    .clk     (clk),
    .rst     (rst),
    .tick_en (tick_en),
    .idx     (cur_step),
    .expire  (dwell_done)
  );

  assign nxt_step = next_of(cur_step, dir_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_step   <= STEP_HOME;
      step_pulse <= 1'b0;
    end else begin
      step_pulse <= 1'b0;
      if (dwell_done) begin
        cur_step   <= nxt_step;
        step_pulse <= (nxt_step != cur_step);
      end
    end
  end

  assign coil = coil_of(cur_step);

  // R1: reset leaves the home pattern and no strobe
  p_reset_home_r1: assert property (@(posedge clk)
    rst |=> coil == 4'b0101 && !step_pulse);
  // R2: exactly two coil lines energised in every pattern
  p_two_lines_r2: assert property (@(posedge clk) disable iff (rst)
    $countones(coil) == 2);
  // R3: clockwise from home goes to 0110
  p_cw_home_r3: assert property (@(posedge clk) disable iff (rst)
    dwell_done && dir_sel == 2'b10 && coil == 4'b0101 |=> coil == 4'b0110);
  // R4: counter-clockwise from home goes to 1001
  p_ccw_home_r4: assert property (@(posedge clk) disable iff (rst)
    dwell_done && dir_sel == 2'b01 && coil == 4'b0101 |=> coil == 4'b1001);
  // R5: neither or both inputs hold the step
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    dwell_done && (dir_sel == 2'b00 || dir_sel == 2'b11) |=> $stable(coil) && !step_pulse);
  // R9: no change of step outside a dwell expiry
  p_only_expiry_r9: assert property (@(posedge clk) disable iff (rst)
    !dwell_done |=> $stable(coil));
  // R10: strobe exactly when the pattern changes
  p_strobe_change_r10: assert property (@(posedge clk) disable iff (rst)
    step_pulse == !$stable(coil));
endmodule

// File: tb/sim_stepper_seq.sv
`timescale 1ns/1ps
module sim_stepper_seq;
  localparam int D0 = 3, D1 = 5, D2 = 2, D3 = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_en = 1'b0;
  logic dir_cw = 1'b0;
  logic dir_ccw = 1'b0;
  logic [3:0] coil;
  logic step_pulse;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  stepper_seq #(.DWELL_0(D0), .DWELL_1(D1), .DWELL_2(D2), .DWELL_3(D3)) u0 (
    .clk(clk), .rst(rst), .tick_en(tick_en), .dir_cw(dir_cw),
    .dir_ccw(dir_ccw), .coil(coil), .step_pulse(step_pulse));

  function automatic int dwell_for(input logic [3:0] c);
    case (c)
      4'b0101: return D0;
      4'b0110: return D1;
      4'b1010: return D2;
      default: return D3;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; tick_en = 1'b0; dir_cw = 1'b0; dir_ccw = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // Counts clock edges until the coil pattern changes (sampled at negedges)
  task automatic measure(output int n);
    logic [3:0] old;
    old = coil;
    n = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      n++;
      if (coil != old) break;
    end
  endtask

  task automatic t_reset();
    do_reset();
    check(coil == 4'b0101, "R1 coil", coil, 4'b0101);
    check(step_pulse == 1'b0, "R1 strobe", step_pulse, 0);
  endtask

  task automatic t_walk(input bit cw);
    logic [3:0] seq_cw [4] = '{4'b0110, 4'b1010, 4'b1001, 4'b0101};
    logic [3:0] seq_ccw[4] = '{4'b1001, 4'b1010, 4'b0110, 4'b0101};
    int n;
    int exp_n;
    do_reset();
    dir_cw = cw; dir_ccw = !cw;
    repeat (3) @(negedge clk);
    tick_en = 1'b1;
    for (int k = 0; k < 4; k++) begin
      exp_n = dwell_for(coil);
      measure(n);
      if (cw) check(coil == seq_cw[k], "R3 cw order", coil, seq_cw[k]);
      else    check(coil == seq_ccw[k], "R4 ccw order", coil, seq_ccw[k]);
      check(n == exp_n, "R6 dwell edges", n, exp_n);
      check(step_pulse == 1'b1, "R10 strobe on change", step_pulse, 1);
    end
    @(negedge clk);
    check(step_pulse == 1'b0, "R10 strobe one cycle", step_pulse, 0);
    tick_en = 1'b0;
  endtask

  task automatic t_hold(input bit cw, input bit ccw);
    bit ok = 1'b1;
    do_reset();
    dir_cw = cw; dir_ccw = ccw;
    repeat (3) @(negedge clk);
    tick_en = 1'b1;
    for (int i = 0; i < 3 * D0 + 3; i++) begin
      @(negedge clk);
      if (coil != 4'b0101 || step_pulse) ok = 1'b0;
    end
    check(ok, "R5 hold neither/both", coil, 4'b0101);
    tick_en = 1'b0;
  endtask

  task automatic t_freeze();
    bit ok = 1'b1;
    int n;
    do_reset();
    dir_cw = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (coil != 4'b0101 || step_pulse) ok = 1'b0;
    end
    check(ok, "R7 frozen without tick", coil, 4'b0101);
    tick_en = 1'b1;
    measure(n);
    check(n == D0, "R7 count did not move", n, D0);
    check(coil == 4'b0110, "R2 pattern after step", coil, 4'b0110);
    tick_en = 1'b0;
  endtask

  task automatic t_reload();
    int n;
    do_reset();
    tick_en = 1'b1;
    repeat (D0 + 1) @(negedge clk);
    tick_en = 1'b0;
    check(coil == 4'b0101, "R5 self-loop kept step", coil, 4'b0101);
    dir_cw = 1'b1;
    repeat (3) @(negedge clk);
    tick_en = 1'b1;
    measure(n);
    check(n == D0 - 1, "R8 reload on self-loop", n, D0 - 1);
    tick_en = 1'b0;
  endtask

  task automatic t_sampled_only();
    bit ok = 1'b1;
    do_reset();
    dir_cw = 1'b1;
    repeat (5) @(negedge clk);
    dir_cw = 1'b0;
    repeat (5) @(negedge clk);
    tick_en = 1'b1;
    for (int i = 0; i < 3 * D0; i++) begin
      @(negedge clk);
      if (coil != 4'b0101) ok = 1'b0;
    end
    check(ok, "R9 pulse between expiries ignored", coil, 4'b0101);
    tick_en = 1'b0;
  endtask

  task automatic t_sync_latency();
    int n;
    do_reset();
    dir_cw = 1'b1;
    repeat (3) @(negedge clk);
    tick_en = 1'b1;
    measure(n);
    measure(n);
    tick_en = 1'b0;
    check(coil == 4'b1010, "R3 reached third step", coil, 4'b1010);
    dir_cw = 1'b0;
    repeat (3) @(negedge clk);
    dir_cw = 1'b1; tick_en = 1'b1;
    measure(n);
    check(n == 2 * D2, "R9 two-flop latency", n, 2 * D2);
    check(coil == 4'b1001, "R2 coil lines 3 and 0", coil, 4'b1001);
    tick_en = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    bad++;
    total++;
    $display("FAIL watchdog expired R1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_walk(1'b1);
    t_walk(1'b0);
    t_hold(1'b0, 1'b0);
    t_hold(1'b1, 1'b1);
    t_freeze();
    t_reload();
    t_sampled_only();
    t_sync_latency();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule